// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the status-register side of the slave logic in a serial NOR flash. It watches an SPI link (SPI mode 0 or mode 3) while chip select is low. It decodes the first byte of each frame as an instruction, and acts on a frame when chip select returns high. It keeps a write-enable latch, a lock bit and three protection bits. It runs a busy timer after every accepted status write. It also holds a sticky flag that records whether the device has been switched to its parallel access mode.

All SPI inputs are sampled by the system clock. The host reads the status byte with a read command, which repeats the byte for as long as the frame stays open. The host changes the status byte with an enable command followed by a two-byte write frame. A write-protect pin, together with the lock bit, can freeze the status byte against every write.

Top module: `flash_status_ctl`

## Requirements
- R1: After reset the status byte reads 00h, `par_mode` is 0 and `so_oe` is 0.
- R2: Opcode 05h starts a status read. From the SCK fall that follows the eighth opcode bit, `so_oe` is 1 and `so` drives the status byte MSB first, changing on SCK falls and restarting at bit 7 after each 8 bits. `so_oe` goes to 0 once chip select is high. Status layout: bit 7 lock, bits 6:5 always 0, bits 4:2 protection, bit 1 write-enable latch, bit 0 busy.
- R3: Opcode 06h in a frame of exactly 8 clocks sets the write-enable latch, unless busy is set.
- R4: Opcode 01h with one data byte, in a frame of exactly 16 clocks, loads data bit 7 into the lock bit and data bits 4:2 into the protection bits. Data bits 6:5 are dropped.
- R5: A status write made while the write-enable latch is 0 changes nothing.
- R6: A status write never loads bits 1:0 from its data. An accepted write sets busy for BUSY_CYCLES clocks. When busy clears, the write-enable latch clears in the same cycle.
- R7: A status-write frame of any length other than 16 clocks is discarded.
- R8: While the lock bit is 1 and `wp_n` is low, every status write is ignored.
- R9: A status write received while busy is set is ignored.
- R10: Opcode 55h sets `par_mode` and opcode 45h clears it, each only in a frame of exactly 8 clocks. The flag persists across other commands until one of these opcodes or a reset changes it.
- R11: Frames with SCK idling low (mode 0) and with SCK idling high (mode 3) are decoded the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low chip select, frames a command |
| si | input | 1 | Serial data in, MSB first, taken on SCK rise |
| wp_n | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| par_mode | output | 1 | Parallel-mode flag |

## Verification
The checker assumes that `sck`, `cs_n` and `si` change slowly compared with `clk`, so that each SCK level lasts at least two clock cycles and every edge is seen as one rise or one fall. It also assumes that `wp_n` is steady within a frame. The bench drives all inputs on the falling edge of `clk` and holds each SCK half period for four cycles. It changes `wp_n` only while chip select is high. It samples `so` and `so_oe` just before each SCK rise, well after the fall that updated them.

// File: rtl/flash_status_ctl.sv
module flash_status_ctl #(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe,
  output logic par_mode
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PON  = 8'h55;
  localparam logic [7:0] OP_POFF = 8'h45;

  logic          sck_q, cs_q;
  logic [4:0]    bit_cnt;
  logic [15:0]   shreg;
  logic          rd_act;
  logic [2:0]    rd_ptr;
  logic          lock_q, wel_q;
  logic [2:0]    prot_q;
  logic [CW-1:0] busy_cnt;
  logic          busy;

  wire sck_rise = sck & ~sck_q;
  wire sck_fall = ~sck & sck_q;
  wire cs_rise  = cs_n & ~cs_q;
  wire [7:0] next_byte = {shreg[6:0], si};
  wire [7:0] status    = {lock_q, 2'b00, prot_q, wel_q, busy};

  wire frame8  = cs_rise && (bit_cnt == 5'd8);
  wire frame16 = cs_rise && (bit_cnt == 5'd16);
  wire hw_lock = lock_q & ~wp_n;
  wire wren_ok = frame8 && (shreg[7:0] == OP_WREN) && !busy;
  wire wrsr_ok = frame16 && (shreg[15:8] == OP_WRSR) && wel_q && !busy && !hw_lock;
  wire pon     = frame8 && (shreg[7:0] == OP_PON);
  wire poff    = frame8 && (shreg[7:0] == OP_POFF);

  assign busy = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      rd_act  <= 1'b0;
    end else if (cs_n) begin
      bit_cnt <= '0;
      rd_act  <= 1'b0;
    end else if (sck_rise) begin
      shreg <= {shreg[14:0], si};
      if (bit_cnt != 5'd31) bit_cnt <= bit_cnt + 5'd1;
      if (bit_cnt == 5'd7 && next_byte == OP_RDSR) rd_act <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= 3'd7;
      so     <= 1'b0;
      so_oe  <= 1'b0;
    end else if (cs_n) begin
      rd_ptr <= 3'd7;
      so_oe  <= 1'b0;
    end else if (sck_fall && rd_act) begin
      so     <= status[rd_ptr];
      rd_ptr <= rd_ptr - 3'd1;
      so_oe  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      prot_q   <= '0;
      wel_q    <= 1'b0;
      busy_cnt <= '0;
      par_mode <= 1'b0;
    end else begin
      if (wrsr_ok) begin
        lock_q   <= shreg[7];
        prot_q   <= shreg[4:2];
        busy_cnt <= CW'(BUSY_CYCLES);
      end else if (busy) begin
        busy_cnt <= busy_cnt - CW'(1);
      end
      if (busy_cnt == CW'(1)) wel_q <= 1'b0;
      else if (wren_ok)       wel_q <= 1'b1;
      if (pon)       par_mode <= 1'b1;
      else if (poff) par_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_status_ctl_chk.sv
module flash_status_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_n,
  input logic       so_oe,
  input logic       par_mode,
  input logic       lock_q,
  input logic [2:0] prot_q,
  input logic       wel_q,
  input logic       busy
);
  AST_SO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !so_oe); // R2
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wel_q)); // R5
  AST_WEL_DROPS_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel_q); // R6
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (lock_q && !wp_n) |=> ($stable(lock_q) && $stable(prot_q))); // R8
  AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ($stable(lock_q) && $stable(prot_q))); // R9
  AST_PAR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |=> $stable(par_mode)); // R10
endmodule

bind flash_status_ctl flash_status_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .so_oe(so_oe),
  .par_mode(par_mode), .lock_q(lock_q), .prot_q(prot_q), .wel_q(wel_q), .busy(busy)
);

// File: tb/flash_status_ctl_bench.sv
module flash_status_ctl_bench;
  localparam int BUSY = 600;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, par_mode;
  int checks = 0, fails = 0;
  logic m3 = 1'b0;

  always #5 clk = ~clk;

  flash_status_ctl #(.BUSY_CYCLES(BUSY)) u_flash_status_ctl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .par_mode(par_mode)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cs_n = 1'b1; sck = m3;
    wait_clk(3); rst_n = 1'b1; wait_clk(3);
  endtask

  task automatic sbit(input logic b, output logic r, output logic oe);
    @(negedge clk); sck = 1'b0; si = b;
    wait_clk(H);
    r = so; oe = so_oe;
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic open_frame();
    @(negedge clk); sck = m3; cs_n = 1'b0; wait_clk(H);
  endtask

  task automatic close_frame();
    @(negedge clk); sck = m3; wait_clk(H);
    cs_n = 1'b1; wait_clk(H);
  endtask

  task automatic frame(input logic [23:0] bits, input int n);
    logic r, oe;
    open_frame();
    for (int i = n - 1; i >= 0; i--) sbit(bits[i], r, oe);
    close_frame();
  endtask

  task automatic read_sr(output logic [7:0] a, output logic [7:0] b, output logic oe_all);
    logic r, oe;
    oe_all = 1'b1;
    open_frame();
    for (int i = 7; i >= 0; i--) sbit(logic'(8'h05 >> i), r, oe);
    for (int i = 7; i >= 0; i--) begin sbit(1'b0, r, oe); a[i] = r; oe_all &= oe; end
    for (int i = 7; i >= 0; i--) begin sbit(1'b0, r, oe); b[i] = r; oe_all &= oe; end
    close_frame();
  endtask

  task automatic expect_sr(input string req, input logic [7:0] exp);
    logic [7:0] a, b; logic oe;
    read_sr(a, b, oe);
    chk(req, a, exp);
    chk({req, " repeat"}, b, exp);
    chk("R2 so_oe during read", {7'd0, oe}, 8'd1);
    chk("R2 so_oe after frame", {7'd0, so_oe}, 8'd0);
  endtask

  task automatic wren();  frame(24'h06, 8); endtask
  task automatic wrsr(input logic [7:0] d); frame({8'h01, d}, 16); endtask

  task automatic t_reset();
    do_reset();
    chk("R1 par_mode", {7'd0, par_mode}, 8'd0);
    chk("R1 so_oe", {7'd0, so_oe}, 8'd0);
    expect_sr("R1 status", 8'h00);
  endtask

  task automatic t_no_wel();
    wrsr(8'hFF);
    expect_sr("R5 write without latch", 8'h00);
  endtask

  task automatic t_wren();
    wren();
    expect_sr("R3 latch set", 8'h02);
  endtask

  task automatic t_write();
    wrsr(8'hFF);
    expect_sr("R4 R6 accepted write busy", 8'h9F);
    wait_clk(BUSY + 50);
    expect_sr("R6 latch cleared after busy", 8'h9C);
  endtask

  task automatic t_low_bits();
    wren();
    wrsr(8'h00);
    expect_sr("R6 low bits not from data", 8'h03);
    wait_clk(BUSY + 50);
    expect_sr("R6 cleared", 8'h00);
  endtask

  task automatic t_busy();
    wren();
    wrsr(8'h1C);
    expect_sr("R9 busy write", 8'h1F);
    wrsr(8'h00);
    wait_clk(BUSY + 50);
    expect_sr("R9 write while busy ignored", 8'h1C);
  endtask

  task automatic t_len();
    wren();
    frame({7'd0, 8'h01, 8'h00, 1'b0}, 17);
    expect_sr("R7 17-clock frame", 8'h1E);
    frame({8'h01, 8'h00} >> 1, 15);
    expect_sr("R7 15-clock frame", 8'h1E);
    wrsr(8'h00);
    wait_clk(BUSY + 50);
    expect_sr("R7 exact frame works", 8'h00);
  endtask

  task automatic t_hpm();
    wren(); wrsr(8'h80); wait_clk(BUSY + 50);
    expect_sr("R4 lock set", 8'h80);
    wp_n = 1'b0;
    wren(); wrsr(8'h00);
    expect_sr("R8 locked write ignored", 8'h82);
    wp_n = 1'b1;
    wrsr(8'h00);
    expect_sr("R8 unlocked write", 8'h03);
    wait_clk(BUSY + 50);
    expect_sr("R8 unlocked result", 8'h00);
  endtask

  task automatic t_par();
    frame(24'h55, 8);
    chk("R10 enter", {7'd0, par_mode}, 8'd1);
    expect_sr("R10 read in par mode", 8'h00);
    chk("R10 persists", {7'd0, par_mode}, 8'd1);
    frame({15'd0, 8'h45, 1'b0}, 9);
    chk("R10 9-clock exit ignored", {7'd0, par_mode}, 8'd1);
    frame(24'h45, 8);
    chk("R10 exit", {7'd0, par_mode}, 8'd0);
    frame(24'h55, 8);
    chk("R10 re-enter", {7'd0, par_mode}, 8'd1);
    do_reset();
    chk("R1 R10 reset clears par", {7'd0, par_mode}, 8'd0);
  endtask

  task automatic t_mode3();
    m3 = 1'b1;
    @(negedge clk); sck = 1'b1; wait_clk(H);
    wren();
    expect_sr("R11 mode3 latch", 8'h02);
    wrsr(8'h0C);
    wait_clk(BUSY + 50);
    expect_sr("R11 mode3 write", 8'h0C);
    m3 = 1'b0;
    @(negedge clk); sck = 1'b0; wait_clk(H);
    expect_sr("R11 back to mode0", 8'h0C);
  endtask

  initial begin
    t_reset();
    t_no_wel();
    t_wren();
    t_write();
    t_low_bits();
    t_busy();
    t_len();
    t_hpm();
    t_par();
    t_mode3();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule